// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading translation entries from memory. The walk begins in a per-context table: the context table pointer and the context number select its first word. Then up to three levels of tables follow, each indexed by a slice of the virtual address. Each memory access is one 32-bit word over a simple port. The port carries a request strobe with an address, plus a write flag and write data. A valid strobe answers each request, and carries the read data for a read. Only one request is outstanding at any time.

A walk ends in one of two ways. It can reach a page entry at level 1, 2 or 3, which maps a 16 MB, 256 KB or 4 KB page. In that case the walker returns the physical address, a page-size code, the final entry and the entry's three permission bits. Or it can stop at a bad entry. In that case it returns a fault code that gives both the level and the cause. When a page entry lacks its referenced bit, or a store meets an entry whose modified bit is clear, the walker sets those bits and writes the entry back to the address it was read from before finishing. A caller pulses `start` and waits for the one-cycle `done` pulse. It may then read the results, which hold until the next walk.

Top module: `pgwalk_top`

## Requirements
- R1: The first read of a walk goes to `{ctx_root,4'b0} + ctx_num*4`.
- R2: A table descriptor (entry bits [1:0] = 1) holds a pointer in bits [31:2]. The next read goes to `{desc[31:2],6'b0}` plus four times the index. The index is vaddr[31:24] for level 1, vaddr[23:18] for level 2 and vaddr[17:12] for level 3.
- R3: A page entry (bits [1:0] = 2) read at level 3 completes the walk with `paddr = {entry[31:8],12'b0} + vaddr[11:0]` and `page_size` = 3, which means 4 KB.
- R4: A page entry at level 1 gives `paddr = {entry[31:8],12'b0} + vaddr[23:0]` and `page_size` = 1, which means 16 MB.
- R5: A page entry at level 2 gives `paddr = {entry[31:8],12'b0} + vaddr[17:0]` and `page_size` = 2, which means 256 KB.
- R6: An invalid entry (bits [1:0] = 0) ends the walk with `fault` high and `fault_code = level<<8 | 1<<2`. The level is 0 for the context entry and 1 to 3 for the tables.
- R7: Three cases end the walk with `fault_code = level<<8 | 4<<2`: a reserved entry (bits [1:0] = 3) at any level, a page entry at the context level, and a table descriptor at level 3.
- R8: Entry bit 5 is the referenced bit and bit 6 is the modified bit. A page entry gets one write back to its own address in two cases: its referenced bit is clear, or the access is a store and its modified bit is clear. The written value sets bit 5, and also sets bit 6 for a store. The `entry` output then shows that value.
- R9: A page entry that needs neither bit, and any walk that faults, causes no write.
- R10: `busy` rises only on the cycle after an accepted `start`. A `start` received while a walk is in progress is ignored.
- R11: `done` is a one-cycle pulse. `mem_req` is only asserted while `busy` is high, and only once per memory response.
- R12: `perm` equals bits [4:2] of the final entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| ctx_root | input | 32 | Context table pointer, byte address >> 4 |
| ctx_num | input | CTX_W | Context number |
| vaddr | input | 32 | Virtual address to translate |
| is_store | input | 1 | Access is a store |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 10 | level<<8 \| cause<<2 |
| page_size | output | 2 | 1=16 MB, 2=256 KB, 3=4 KB, 0 on fault |
| paddr | output | 36 | Translated physical address |
| entry | output | 32 | Final entry (after bit update) |
| perm | output | 3 | Permission field of final entry |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 36 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Response strobe |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions check the following on every cycle: `done` is a single-cycle pulse, memory requests appear only while busy, `busy` rises only after a start, every write-back sets the referenced bit, every fault code has the legal shape, and every successful walk carries a page size. Directed scenarios cover the rest, because each needs a prepared table image and an expected address. These are the address arithmetic at each level, the three page sizes, the level-tagged faults for each entry type, the choice between write-back and no write, and the rejection of a second start under slow memory.

// File: rtl/pgwalk_pkg.sv
// Shared types and constants for the translation table walker.
// Assumes 32-bit entries with the type in bits [1:0].
package pgwalk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_CTX, ST_RD_L1, ST_RD_L2, ST_RD_L3, ST_WBACK, ST_DONE
    } walk_state_t;

    localparam logic [1:0] ET_INVALID = 2'd0;
    localparam logic [1:0] ET_TABLE   = 2'd1;
    localparam logic [1:0] ET_PAGE    = 2'd2;
    localparam logic [1:0] ET_RSVD    = 2'd3;

    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_BADTYPE = 3'd4;

    localparam int ENT_W  = 32;
    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;
    localparam int PPN_LO  = 8;
endpackage

// File: rtl/pgwalk_addr.sv
// Next read address generator.
// Level 0 addresses the context table, levels 1..3 index the table named by
// the previous descriptor with a slice of the virtual page number.
// Assumes PA_W = 30 + 6 so a shifted descriptor pointer fills the address.
module pgwalk_addr #(
    parameter int CTX_W  = 8,
    parameter int PA_W   = 36,
    parameter int I1_W   = 8,
    parameter int I2_W   = 6,
    parameter int I3_W   = 6
) (
    input  logic [1:0]                 lvl,
    input  logic [PA_W-5:0]            root,
    input  logic [CTX_W-1:0]           ctx,
    input  logic [31:2]                desc_ptr,
    input  logic [I1_W+I2_W+I3_W-1:0]  vpn,
    output logic [PA_W-1:0]            addr
);
    localparam int VPN_W = I1_W + I2_W + I3_W;

    logic [PA_W-1:0] ctx_base;
    logic [PA_W-1:0] tbl_base;
    logic [PA_W-1:0] idx_off;

    // Base addresses for the context table and for a pointed-to table
    always_comb begin
        ctx_base = {root, 4'b0000};
        tbl_base = PA_W'({desc_ptr, 6'b000000});
    end

    // Select the word index for the requested level
    always_comb begin
        case (lvl)
            2'd1:    idx_off = PA_W'({vpn[VPN_W-1 -: I1_W], 2'b00});
            2'd2:    idx_off = PA_W'({vpn[I2_W+I3_W-1 -: I2_W], 2'b00});
            2'd3:    idx_off = PA_W'({vpn[I3_W-1:0], 2'b00});
            default: idx_off = PA_W'({ctx, 2'b00});
        endcase
    end

    // Final address: base chosen by level plus the index offset
    always_comb begin
        addr = ((lvl == 2'd0) ? ctx_base : tbl_base) + idx_off;
    end
endmodule

// File: rtl/pgwalk_decode.sv
// Entry classifier: decides whether an entry read at a given level
// continues the walk, ends it with a page, or ends it with a fault.
// Fault code layout is level in [9:8] and cause in [4:2].
module pgwalk_decode
    import pgwalk_pkg::*;
(
    input  logic [1:0] lvl,
    input  logic [1:0] etype,
    output logic       is_next,
    output logic       is_leaf,
    output logic       is_fault,
    output logic [9:0] code
);
    logic [2:0] cause;

    // Classify by entry type, with level-dependent misplacement rules
    always_comb begin
        is_next  = 1'b0;
        is_leaf  = 1'b0;
        is_fault = 1'b0;
        cause    = 3'd0;
        case (etype)
            ET_INVALID: begin is_fault = 1'b1; cause = FT_INVALID; end
            ET_RSVD:    begin is_fault = 1'b1; cause = FT_BADTYPE; end
            ET_PAGE: begin
                if (lvl == 2'd0) begin is_fault = 1'b1; cause = FT_BADTYPE; end
                else              is_leaf  = 1'b1;
            end
            default: begin
                if (lvl == 2'd3) begin is_fault = 1'b1; cause = FT_BADTYPE; end
                else              is_next  = 1'b1;
            end
        endcase
    end

    // Pack the level-tagged fault code
    always_comb begin
        code = is_fault ? {lvl, 3'b000, cause, 2'b00} : 10'd0;
    end
endmodule

// File: rtl/pgwalk_leaf.sv
// Page entry resolver: forms the physical address from the entry's page
// number and the in-page offset that the leaf level selects, and decides
// whether the referenced/modified bits must be written back.
module pgwalk_leaf #(
    parameter int PA_W   = 36,
    parameter int PAGE_W = 12,
    parameter int I2_W   = 6,
    parameter int I3_W   = 6
) (
    input  logic [1:0]                   lvl,
    input  logic [31:8]                  ppn,
    input  logic                         ref_bit,
    input  logic                         mod_bit,
    input  logic                         is_store,
    input  logic [PAGE_W+I2_W+I3_W-1:0]  va_lo,
    output logic [PA_W-1:0]              pa,
    output logic                         need_wb,
    output logic                         set_mod
);
    localparam int LO_W = PAGE_W + I2_W + I3_W;

    logic [PA_W-1:0] off [1:3];

    // One offset per leaf level, widest for level 1
    for (genvar k = 1; k <= 3; k++) begin : g_off
        localparam int W = PAGE_W + ((k <= 1) ? I2_W : 0) + ((k <= 2) ? I3_W : 0);
        assign off[k] = PA_W'(va_lo[W-1:0]);
    end

    // Physical address: page frame plus the level's offset
    always_comb begin
        pa = PA_W'({ppn, {PAGE_W{1'b0}}}) + ((lvl == 2'd0) ? '0 : off[lvl]);
    end

    // Write-back needed when referenced is missing or a store finds modified clear
    always_comb begin
        set_mod = is_store && !mod_bit;
        need_wb = !ref_bit || set_mod;
    end

    logic unused_lo;
    assign unused_lo = ^va_lo[LO_W-1:0] & 1'b0;
endmodule

// File: rtl/pgwalk_top.sv
// Translation table walker top: FSM that reads the context entry, then up
// to three table levels, optionally writes back the updated page entry and
// presents the result for one cycle of done. One walk at a time; start is
// ignored while busy. The memory port allows one request in flight; every
// request, read or write, is answered by one mem_rvalid pulse.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int CTX_W  = 8,
    parameter int PAGE_W = 12,
    parameter int I1_W   = 8,
    parameter int I2_W   = 6,
    parameter int I3_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [31:0]              ctx_root,
    input  logic [CTX_W-1:0]         ctx_num,
    input  logic [31:0]              vaddr,
    input  logic                     is_store,
    output logic                     busy,
    output logic                     done,
    output logic                     fault,
    output logic [9:0]               fault_code,
    output logic [1:0]               page_size,
    output logic [35:0]              paddr,
    output logic [31:0]              entry,
    output logic [2:0]               perm,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [35:0]              mem_addr,
    output logic [31:0]              mem_wdata,
    input  logic                     mem_rvalid,
    input  logic [31:0]              mem_rdata
);
    localparam int VA_W  = PAGE_W + I1_W + I2_W + I3_W;
    localparam int VPN_W = I1_W + I2_W + I3_W;
    localparam int LO_W  = PAGE_W + I2_W + I3_W;
    localparam int PA_W  = 36;

    walk_state_t      state;
    logic             issued;
    logic [VA_W-1:0]  va_q;
    logic [31:0]      root_q;
    logic [CTX_W-1:0] ctx_q;
    logic             store_q;
    logic [PA_W-1:0]  addr_q;
    logic [31:0]      wdata_q;

    logic [1:0]       cur_lvl;
    logic [1:0]       gen_lvl;
    logic [PA_W-1:0]  gen_addr;
    logic             dec_next, dec_leaf, dec_fault;
    logic [9:0]       dec_code;
    logic [PA_W-1:0]  leaf_pa;
    logic             leaf_wb, leaf_setm;
    logic [31:0]      wb_value;

    // Level of the entry currently being read
    always_comb begin
        case (state)
            ST_RD_L1: cur_lvl = 2'd1;
            ST_RD_L2: cur_lvl = 2'd2;
            ST_RD_L3: cur_lvl = 2'd3;
            default:  cur_lvl = 2'd0;
        endcase
    end

    // Address generator level: context when idle, otherwise the next level
    assign gen_lvl = (state == ST_IDLE) ? 2'd0 : cur_lvl + 2'd1;

    pgwalk_addr #(.CTX_W(CTX_W), .PA_W(PA_W), .I1_W(I1_W), .I2_W(I2_W), .I3_W(I3_W)) u_addr (
        .lvl      (gen_lvl),
        .root     ((state == ST_IDLE) ? ctx_root : root_q),
        .ctx      ((state == ST_IDLE) ? ctx_num  : ctx_q),
        .desc_ptr (mem_rdata[31:2]),
        .vpn      (va_q[VA_W-1 -: VPN_W]),
        .addr     (gen_addr)
    );

    pgwalk_decode u_dec (
        .lvl      (cur_lvl),
        .etype    (mem_rdata[1:0]),
        .is_next  (dec_next),
        .is_leaf  (dec_leaf),
        .is_fault (dec_fault),
        .code     (dec_code)
    );

    pgwalk_leaf #(.PA_W(PA_W), .PAGE_W(PAGE_W), .I2_W(I2_W), .I3_W(I3_W)) u_leaf (
        .lvl      (cur_lvl),
        .ppn      (mem_rdata[31:PPN_LO]),
        .ref_bit  (mem_rdata[REF_BIT]),
        .mod_bit  (mem_rdata[MOD_BIT]),
        .is_store (store_q),
        .va_lo    (va_q[LO_W-1:0]),
        .pa       (leaf_pa),
        .need_wb  (leaf_wb),
        .set_mod  (leaf_setm)
    );

    // Updated entry value for the write-back
    always_comb begin
        wb_value = mem_rdata;
        wb_value[REF_BIT] = 1'b1;
        if (leaf_setm) wb_value[MOD_BIT] = 1'b1;
    end

    // Memory port: one request per state visit, held address
    assign mem_req   = (state inside {ST_RD_CTX, ST_RD_L1, ST_RD_L2, ST_RD_L3, ST_WBACK}) && !issued;
    assign mem_we    = (state == ST_WBACK);
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

    // Status decoded from state
    assign busy = (state != ST_IDLE) && (state != ST_DONE);
    assign done = (state == ST_DONE);
    assign perm = entry[4:2];

    // Walk sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            issued     <= 1'b0;
            va_q       <= '0;
            root_q     <= '0;
            ctx_q      <= '0;
            store_q    <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            fault      <= 1'b0;
            fault_code <= '0;
            page_size  <= '0;
            paddr      <= '0;
            entry      <= '0;
        end else begin
            if (mem_req) issued <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        va_q       <= vaddr;
                        root_q     <= ctx_root;
                        ctx_q      <= ctx_num;
                        store_q    <= is_store;
                        addr_q     <= gen_addr;
                        issued     <= 1'b0;
                        fault      <= 1'b0;
                        fault_code <= '0;
                        page_size  <= '0;
                        paddr      <= '0;
                        state      <= ST_RD_CTX;
                    end
                end
                ST_RD_CTX, ST_RD_L1, ST_RD_L2, ST_RD_L3: begin
                    if (mem_rvalid && issued) begin
                        entry <= mem_rdata;
                        if (dec_fault) begin
                            fault      <= 1'b1;
                            fault_code <= dec_code;
                            state      <= ST_DONE;
                        end else if (dec_leaf) begin
                            paddr     <= leaf_pa;
                            page_size <= cur_lvl;
                            if (leaf_wb) begin
                                entry   <= wb_value;
                                wdata_q <= wb_value;
                                issued  <= 1'b0;
                                state   <= ST_WBACK;
                            end else begin
                                state <= ST_DONE;
                            end
                        end else if (dec_next) begin
                            addr_q <= gen_addr;
                            issued <= 1'b0;
                            case (state)
                                ST_RD_CTX: state <= ST_RD_L1;
                                ST_RD_L1:  state <= ST_RD_L2;
                                default:   state <= ST_RD_L3;
                            endcase
                        end
                    end
                end
                ST_WBACK: begin
                    if (mem_rvalid && issued) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Completion strobe never lasts two cycles
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    // Memory is only touched during a walk
    AST_REQ_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R11
    // A walk begins only from a start request
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R10
    // Every write-back carries the referenced bit
    AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[REF_BIT]); // R8
    // Fault codes have only a level and one of the two causes
    AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_code[7:5] == 3'd0 && fault_code[1:0] == 2'd0 &&
                             (fault_code[4:2] == 3'd1 || fault_code[4:2] == 3'd4))); // R7
    // A successful walk always reports a page size
    AST_LEAF_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (page_size != 2'd0)); // R3
endmodule

// File: tb/pgwalk_top_bench.sv
// Directed bench for the translation table walker with a sparse memory model.
module pgwalk_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ROOT = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ctx_root = ROOT;
    logic [7:0]  ctx_num = 8'd0;
    logic [31:0] vaddr = '0;
    logic        is_store = 1'b0;
    logic        busy, done, fault, mem_req, mem_we;
    logic [9:0]  fault_code;
    logic [1:0]  page_size;
    logic [35:0] paddr, mem_addr;
    logic [31:0] entry, mem_wdata;
    logic [2:0]  perm;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int lat = 0;

    logic [31:0] mem [logic [35:0]];
    logic        pend = 1'b0;
    logic        pend_we = 1'b0;
    logic [35:0] pend_a = '0;
    logic [31:0] pend_d = '0;
    int          wait_c = 0;
    int          n_req = 0, n_wr = 0;
    logic [35:0] first_a = '0, last_rd_a = '0, wr_a = '0;
    logic [31:0] wr_d = '0;

    pgwalk_top u_pgwalk_top (
        .clk(clk), .rst_n(rst_n), .start(start), .ctx_root(ctx_root),
        .ctx_num(ctx_num), .vaddr(vaddr), .is_store(is_store),
        .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
        .page_size(page_size), .paddr(paddr), .entry(entry), .perm(perm),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: one response per request after lat extra cycles
    always @(posedge clk) begin
        cycles <= cycles + 1;
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            pend <= 1'b1; pend_a <= mem_addr; pend_we <= mem_we;
            pend_d <= mem_wdata; wait_c <= lat;
            if (n_req == 0) first_a <= mem_addr;
            n_req <= n_req + 1;
            if (!mem_we) last_rd_a <= mem_addr;
        end else if (pend) begin
            if (wait_c == 0) begin
                pend <= 1'b0;
                mem_rvalid <= 1'b1;
                if (pend_we) begin
                    mem[pend_a] = pend_d;
                    n_wr <= n_wr + 1; wr_a <= pend_a; wr_d <= pend_d;
                end else begin
                    mem_rdata <= mem.exists(pend_a) ? mem[pend_a] : 32'h0;
                end
            end else begin
                wait_c <= wait_c - 1;
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports
    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors = errors + 1; checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_tables(input logic [31:0] l3_entry);
        mem.delete();
        mem[36'h0100_000C] = 32'h0020_0001;   // ctx 3 -> L1 table at 0x2000000
        mem[36'h0100_0018] = 32'h0000_0062;   // ctx 6 page entry (misplaced)
        mem[36'h0200_0048] = 32'h0030_0001;   // va[31:24]=0x12 -> L2 table
        mem[36'h0200_0168] = 32'h1200_0062;   // va[31:24]=0x5A: 16 MB page
        mem[36'h0200_01E0] = 32'h0000_0003;   // va[31:24]=0x78: reserved
        mem[36'h0300_0034] = 32'h0040_0001;   // idx 0x0D -> L3 table
        mem[36'h0300_00FC] = 32'h0055_5562;   // idx 0x3F: 256 KB page
        mem[36'h0400_0014] = l3_entry;        // idx 5
        mem[36'h0400_0018] = 32'h0040_0001;   // idx 6: descriptor at level 3
    endtask

    // Start one walk and wait for done (sampled at negedge)
    task automatic walk(input logic [7:0] ctx, input logic [31:0] va, input logic st);
        int t;
        @(negedge clk);
        n_req = 0; n_wr = 0;
        ctx_num = ctx; vaddr = va; is_store = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 500) begin @(negedge clk); t++; end
        check("R11 walk completes", {63'd0, done}, 64'd1);
    endtask

    task automatic t_reset;
        check("R10 reset busy", {63'd0, busy}, 64'd0);
        check("R11 reset done", {63'd0, done}, 64'd0);
        check("R11 reset mem_req", {63'd0, mem_req}, 64'd0);
    endtask

    task automatic t_l3_load;
        load_tables(32'hABCD_EF6E);
        walk(8'd3, 32'h1234_5678, 1'b0);
        check("R1 first read", 64'(first_a), 64'h0100_000C);
        check("R2 read count", 64'(n_req), 64'd4);
        check("R2 L3 address", 64'(last_rd_a), 64'h0400_0014);
        check("R3 paddr 4K", 64'(paddr), 64'hA_BCDE_F678);
        check("R3 size 4K", 64'(page_size), 64'd3);
        check("R3 no fault", 64'(fault), 64'd0);
        check("R12 perm", 64'(perm), 64'd3);
        check("R9 no write", 64'(n_wr), 64'd0);
        @(negedge clk);
        check("R11 done one cycle", {63'd0, done}, 64'd0);
    endtask

    task automatic t_writeback;
        load_tables(32'hABCD_EF2E);
        walk(8'd3, 32'h1234_5678, 1'b1);
        check("R8 store write count", 64'(n_wr), 64'd1);
        check("R8 store write addr", 64'(wr_a), 64'h0400_0014);
        check("R8 store write data", 64'(wr_d), 64'hABCD_EF6E);
        check("R8 entry updated", 64'(entry), 64'hABCD_EF6E);
        load_tables(32'hABCD_EF0E);
        walk(8'd3, 32'h1234_5678, 1'b0);
        check("R8 load sets ref only", 64'(wr_d), 64'hABCD_EF2E);
        check("R8 load write count", 64'(n_wr), 64'd1);
        load_tables(32'hABCD_EF2E);
        walk(8'd3, 32'h1234_5678, 1'b0);
        check("R9 load ref set no write", 64'(n_wr), 64'd0);
        check("R9 entry unchanged", 64'(entry), 64'hABCD_EF2E);
    endtask

    task automatic t_large_pages;
        load_tables(32'hABCD_EF6E);
        walk(8'd3, 32'h5A7B_C123, 1'b0);
        check("R4 paddr 16M", 64'(paddr), 64'h1_207B_C123);
        check("R4 size 16M", 64'(page_size), 64'd1);
        check("R4 reads", 64'(n_req), 64'd2);
        walk(8'd3, 32'h12FC_0ABC, 1'b0);
        check("R5 paddr 256K", 64'(paddr), 64'h0_0555_5ABC);
        check("R5 size 256K", 64'(page_size), 64'd2);
        check("R2 L2 address", 64'(last_rd_a), 64'h0300_00FC);
    endtask

    task automatic t_faults;
        load_tables(32'hABCD_EF6E);
        walk(8'd5, 32'h1234_5678, 1'b0);
        check("R6 ctx invalid", {53'd0, fault, fault_code}, {53'd0, 1'b1, 10'h004});
        walk(8'd3, 32'h7700_0000, 1'b0);
        check("R6 L1 invalid", 64'(fault_code), 64'h104);
        walk(8'd3, 32'h12C0_0000, 1'b0);
        check("R6 L2 invalid", 64'(fault_code), 64'h204);
        walk(8'd3, 32'h1234_7678, 1'b0);
        check("R6 L3 invalid", 64'(fault_code), 64'h304);
        walk(8'd6, 32'h1234_5678, 1'b0);
        check("R7 page at ctx", {53'd0, fault, fault_code}, {53'd0, 1'b1, 10'h010});
        walk(8'd3, 32'h7800_0000, 1'b0);
        check("R7 L1 reserved", 64'(fault_code), 64'h110);
        walk(8'd3, 32'h1234_6678, 1'b1);
        check("R7 descriptor at L3", 64'(fault_code), 64'h310);
        check("R9 fault no write", 64'(n_wr), 64'd0);
    endtask

    task automatic t_start_busy;
        int t;
        int dones;
        load_tables(32'hABCD_EF6E);
        lat = 3;
        @(negedge clk);
        n_req = 0; n_wr = 0;
        ctx_num = 8'd3; vaddr = 32'h1234_5678; is_store = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", {63'd0, busy}, 64'd1);
        @(negedge clk); @(negedge clk);
        vaddr = 32'h5A7B_C123; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 500) begin @(negedge clk); t++; end
        check("R10 first walk result kept", 64'(paddr), 64'hA_BCDE_F678);
        dones = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done || busy) dones++;
        end
        check("R10 second start ignored", 64'(dones), 64'd0);
        check("R10 request count", 64'(n_req), 64'd4);
        lat = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_l3_load;
        t_writeback;
        t_large_pages;
        t_faults;
        t_start_busy;
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule